// File: doc/BRIEF.md
# Serial EEPROM Slave Engine (three-wire, start-bit framed)

This block implements the device side of a three-wire serial EEPROM. A host selects it with a chip-select line and clocks instructions in on a serial data input. Every instruction begins with a start bit, followed by two opcode bits and an address field. Writes then carry a data field. The engine holds its storage array in flip-flops and answers reads on a serial data output. It runs the self-timed programming cycles for single-location and whole-array updates.

All three bus inputs are oversampled by a fast system clock and resynchronised. Their edges are detected synchronously, so the serial clock can run at any rate well below the system clock. An organisation input picks one of two array views: 16-bit words, or 8-bit bytes with one more address bit. Each programming cycle is a fixed count of system clocks, set by a parameter, and it starts when chip select falls at the correct moment. The synchronous reset stands for power-on.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is high, zeros sampled on DI before the first 1 are ignored, and that first 1 is the start bit. After the start bit come two opcode bits, then an address field, all MSB first. The address field is AW16 bits wide when `org16` is 1 and AW16+1 bits wide when `org16` is 0. Opcode 10 is read, 01 is write and 11 is erase. Opcode 00 uses the top two address bits as a sub-code: 11 enables programming, 00 disables it, 10 erases the whole array and 01 writes the whole array.
- R2: A read first drives a dummy 0 on DO right after the last address bit. Each following SK rising edge then presents the next data bit, MSB first: 16 bits per location in word mode, 8 in byte mode.
- R3: While chip select stays high, a read moves on to the next location with no dummy bit in between. After the highest location it wraps to location 0.
- R4: Reset leaves every location all ones and programming disabled. A write issued while programming is disabled does not start a cycle and leaves the array unchanged. The disable sub-code restores that state. Reads work whether or not programming is enabled.
- R5: Once programming is enabled, a write stores its data field at the addressed location: a 16-bit word when `org16` is 1, or an 8-bit byte when it is 0.
- R6: An erase sets the addressed location to all ones and leaves the other locations alone.
- R7: A whole-array erase sets every location to all ones. A whole-array write stores its data field in every location. Both still take a full-length address field, whose low bits are ignored.
- R8: While a programming cycle runs, DO is 0 whenever chip select is high, and any instruction clocked in is ignored. After the cycle ends, DO is 1 while chip select is high, and it stays 1 until chip select falls.
- R9: A programming cycle starts only if chip select falls after the last expected bit and before any further SK rising edge. One extra SK edge, or an early fall of chip select, cancels the instruction and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data input, sampled on SK rising edges |
| org16 | input | 1 | 1 selects the 16-bit word view, 0 selects the 8-bit byte view |
| dout | output | 1 | Serial data output: read data or ready/busy status |

## Verification
The bench builds the engine with AW16 = 4, which gives 16 words or 32 bytes. This size makes the top-address wrap and the whole-array operations quick to reach and to read back. PROG_CYCLES = 400 keeps each programming cycle longer than a complete 23-bit write. That lets a second instruction be shifted in and shown to be ignored while the cycle runs. Both organisation settings are covered, including the longer address field in byte mode.

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int AW16        = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org16,
  output logic dout
);
  localparam int AWX = AW16 + 1;
  localparam int NB  = 1 << AWX;
  localparam int HW  = AWX + 2;
  localparam int NBW = $clog2(HW + 1);
  localparam int CW  = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_ARM, S_HOLD} st_t;
  typedef enum logic [1:0] {K_WR, K_ER, K_WRAL, K_ERAL} kind_t;

  logic [2:0]     cs_r, sk_r;
  logic [1:0]     di_r;
  logic [7:0]     mem [NB];
  st_t            st;
  kind_t          pk;
  logic [HW-1:0]  sr;
  logic [NBW-1:0] nb;
  logic [15:0]    dr;
  logic [4:0]     nd;
  logic [3:0]     bit_i;
  logic [AWX-1:0] rd_addr, paddr;
  logic [15:0]    pdata;
  logic [CW-1:0]  cnt;
  logic           w16, wen, stat, rd_out;

  wire cs_s    = cs_r[1];
  wire cs_q    = cs_r[2];
  wire di_s    = di_r[1];
  wire sk_rise = sk_r[1] & ~sk_r[2];
  wire cs_fall = ~cs_s & cs_q;
  wire busy    = (cnt != '0);

  wire [HW-1:0]  sr_n     = {sr[HW-2:0], di_s};
  wire           last_hdr = (nb == (w16 ? NBW'(AW16 + 1) : NBW'(AW16 + 2)));
  wire [1:0]     op       = w16 ? sr_n[AW16+1 -: 2] : sr_n[AW16+2 -: 2];
  wire [1:0]     ext      = w16 ? sr_n[AW16-1 -: 2] : sr_n[AW16 -: 2];
  wire [AWX-1:0] adr      = w16 ? {1'b0, sr_n[AW16-1:0]} : sr_n[AWX-1:0];
  wire           dw_last  = (nd == (w16 ? 5'd15 : 5'd7));
  wire [3:0]     bit_top  = w16 ? 4'd15 : 4'd7;

  wire [15:0] rword = w16 ? {mem[{rd_addr[AW16-1:0], 1'b1}], mem[{rd_addr[AW16-1:0], 1'b0}]}
                          : {8'h00, mem[rd_addr]};
  wire [AWX-1:0] next_addr = w16 ? {1'b0, rd_addr[AW16-1:0] + 1'b1} : rd_addr + 1'b1;

  assign dout = (stat && cs_s) ? ~busy : rd_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_r <= '0; sk_r <= '0; di_r <= '0;
    end else begin
      cs_r <= {cs_r[1:0], cs};
      sk_r <= {sk_r[1:0], sk};
      di_r <= {di_r[0], di};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pk <= K_WR; sr <= '0; nb <= '0; dr <= '0; nd <= '0;
      bit_i <= '0; rd_addr <= '0; paddr <= '0; pdata <= '0; cnt <= '0;
      w16 <= 1'b1; wen <= 1'b0; stat <= 1'b0; rd_out <= 1'b0;
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          case (pk)
            K_WR: begin
              if (w16) begin
                mem[{paddr[AW16-1:0], 1'b0}] <= pdata[7:0];
                mem[{paddr[AW16-1:0], 1'b1}] <= pdata[15:8];
              end else mem[paddr] <= pdata[7:0];
            end
            K_ER: begin
              if (w16) begin
                mem[{paddr[AW16-1:0], 1'b0}] <= 8'hFF;
                mem[{paddr[AW16-1:0], 1'b1}] <= 8'hFF;
              end else mem[paddr] <= 8'hFF;
            end
            K_ERAL: for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
            K_WRAL: for (int i = 0; i < NB; i++)
                      mem[i] <= (w16 && (i % 2 == 1)) ? pdata[15:8] : pdata[7:0];
            default: ;
          endcase
        end
      end

      if (!cs_s) begin
        st     <= S_IDLE;
        rd_out <= 1'b0;
        if (cs_fall) begin
          if (st == S_ARM && wen) begin
            cnt  <= CW'(PROG_CYCLES);
            stat <= 1'b1;
          end else if (!busy) stat <= 1'b0;
        end
      end else if (sk_rise && !busy) begin
        case (st)
          S_IDLE: if (di_s) begin
            st <= S_HDR; sr <= '0; nb <= '0; w16 <= org16; stat <= 1'b0; rd_out <= 1'b0;
          end
          S_HDR: begin
            sr <= sr_n;
            nb <= nb + 1'b1;
            if (last_hdr) begin
              paddr <= adr;
              nd    <= '0;
              case (op)
                2'b10: begin st <= S_READ; rd_addr <= adr; bit_i <= bit_top; rd_out <= 1'b0; end
                2'b01: begin st <= S_DATA; pk <= K_WR; end
                2'b11: begin st <= S_ARM;  pk <= K_ER; end
                default: case (ext)
                  2'b11:   begin st <= S_HOLD; wen <= 1'b1; end
                  2'b00:   begin st <= S_HOLD; wen <= 1'b0; end
                  2'b10:   begin st <= S_ARM;  pk <= K_ERAL; end
                  default: begin st <= S_DATA; pk <= K_WRAL; end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dr <= {dr[14:0], di_s};
            nd <= nd + 1'b1;
            if (dw_last) begin
              st    <= S_ARM;
              pdata <= {dr[14:0], di_s};
            end
          end
          S_READ: begin
            rd_out <= rword[bit_i];
            if (bit_i == 4'd0) begin
              rd_addr <= next_addr;
              bit_i   <= bit_top;
            end else bit_i <= bit_i - 1'b1;
          end
          S_ARM:   st <= S_HOLD;
          default: ;
        endcase
      end
    end
  end

  a_r8_busy_ignores_bus: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == S_IDLE));
  a_r4_cycle_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);
  a_r9_cycle_on_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs_q) && !$past(cs_s)));
  a_r1_quiet_during_header: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR) |-> !dout);
  a_r3_word_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && w16) |-> !rd_addr[AW16]);
endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int AW   = 4;
  localparam int PROG = 400;
  localparam int HALF = 6;
  localparam int NX16 = AW;
  localparam int NX8  = AW + 1;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b1;
  logic dout;
  int total = 0, fails = 0;

  mw_eeprom_slave #(.AW16(AW), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org16(org16), .dout(dout));

  always #2 clk = ~clk;

  localparam logic [19:0] VEC [6] = '{
    {4'd0, 16'h1234}, {4'd15, 16'h8001}, {4'd3, 16'hC0DE},
    {4'd4, 16'h0F0F}, {4'd6, 16'h5AA5}, {4'd9, 16'h7E81}};

  task automatic tick(input int n); repeat (n) @(posedge clk); endtask

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    di = b; tick(HALF); sk = 1'b1; tick(HALF); sk = 1'b0;
  endtask
  task automatic csup; cs = 1'b1; tick(HALF); endtask
  task automatic csdn; cs = 1'b0; tick(HALF); endtask

  task automatic hdr(input logic [1:0] op, input logic [15:0] a, input int n);
    pulse(1'b1); pulse(op[1]); pulse(op[0]);
    for (int i = n - 1; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic special(input logic [1:0] ext, input int n);
    csup; hdr(2'b00, 16'(ext) << (n - 2), n); csdn;
  endtask

  task automatic wr(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                    input int n, input int dw, input int extra, input int dcut);
    csup; hdr(op, a, n);
    for (int i = dw - 1; i >= dcut; i--) pulse(d[i]);
    for (int i = 0; i < extra; i++) pulse(1'b0);
    csdn;
  endtask

  task automatic wait_rdy(input string r, input bit expect_cycle);
    tick(4); csup;
    chk(r, 16'(dout), 16'h0);
    if (expect_cycle) begin
      for (int k = 0; k < 2 * PROG && dout !== 1'b1; k++) tick(1);
      chk(r, 16'(dout), 16'h1);
      tick(20);
      chk(r, 16'(dout), 16'h1);
    end
    csdn;
    chk(r, 16'(dout), 16'h0);
  endtask

  task automatic rd(input logic [15:0] a, input int n, input int dw, input int lead,
                    output logic [15:0] w0, output logic [15:0] w1, output logic dm);
    csup;
    for (int i = 0; i < lead; i++) pulse(1'b0);
    hdr(2'b10, a, n);
    tick(1);
    dm = dout;
    w0 = '0; w1 = '0;
    for (int i = 0; i < dw; i++) begin pulse(1'b0); tick(1); w0 = {w0[14:0], dout}; end
    for (int i = 0; i < dw; i++) begin pulse(1'b0); tick(1); w1 = {w1[14:0], dout}; end
    csdn;
  endtask

  initial begin
    tick(150000);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] w0, w1;
    logic dm;
    tick(5); rst_n = 1'b1; tick(5);
    chk("R4 reset dout", 16'(dout), 16'h0);

    rd(16'd1, NX16, 16, 0, w0, w1, dm);
    chk("R4 reset contents", w0, 16'hFFFF);
    wr(2'b01, 16'd1, 16'h0F0F, NX16, 16, 0, 0);
    wait_rdy("R4 disabled write no cycle", 1'b0);
    rd(16'd1, NX16, 16, 0, w0, w1, dm);
    chk("R4 disabled write ignored", w0, 16'hFFFF);

    special(2'b11, NX16);
    for (int v = 0; v < 6; v++) begin
      wr(2'b01, 16'(VEC[v][19:16]), VEC[v][15:0], NX16, 16, 0, 0);
      wait_rdy("R8 ready after write", 1'b1);
      rd(16'(VEC[v][19:16]), NX16, 16, 0, w0, w1, dm);
      chk("R2 dummy zero", 16'(dm), 16'h0);
      chk("R5 word readback", w0, VEC[v][15:0]);
    end

    rd(16'd15, NX16, 16, 0, w0, w1, dm);
    chk("R3 top word", w0, 16'h8001);
    chk("R3 wrap to zero", w1, 16'h1234);
    rd(16'd3, NX16, 16, 0, w0, w1, dm);
    chk("R3 sequential next", w1, 16'h0F0F);

    rd(16'd0, NX16, 16, 3, w0, w1, dm);
    chk("R1 leading zeros skipped", w0, 16'h1234);

    wr(2'b11, 16'd3, 16'h0, NX16, 0, 0, 0);
    wait_rdy("R8 ready after erase", 1'b1);
    rd(16'd3, NX16, 16, 0, w0, w1, dm);
    chk("R6 erased word", w0, 16'hFFFF);
    chk("R6 neighbour kept", w1, 16'h0F0F);

    wr(2'b01, 16'd5, 16'hBEEF, NX16, 16, 0, 0);
    tick(4); csup;
    chk("R8 busy low", 16'(dout), 16'h0);
    csdn;
    wr(2'b01, 16'd6, 16'h0000, NX16, 16, 0, 0);
    wait_rdy("R8 ready after busy", 1'b1);
    rd(16'd5, NX16, 16, 0, w0, w1, dm);
    chk("R8 first write done", w0, 16'hBEEF);
    chk("R8 write during busy ignored", w1, 16'h5AA5);

    wr(2'b01, 16'd9, 16'h1111, NX16, 16, 1, 0);
    wait_rdy("R9 extra clock no cycle", 1'b0);
    rd(16'd9, NX16, 16, 0, w0, w1, dm);
    chk("R9 extra clock aborts", w0, 16'h7E81);
    wr(2'b01, 16'd9, 16'h2222, NX16, 16, 0, 1);
    wait_rdy("R9 early fall no cycle", 1'b0);
    rd(16'd9, NX16, 16, 0, w0, w1, dm);
    chk("R9 early fall aborts", w0, 16'h7E81);

    wr(2'b00, 16'h1 << (NX16 - 2), 16'hA55A, NX16, 16, 0, 0);
    wait_rdy("R7 ready after fill", 1'b1);
    rd(16'd15, NX16, 16, 0, w0, w1, dm);
    chk("R7 fill top", w0, 16'hA55A);
    chk("R7 fill bottom", w1, 16'hA55A);
    wr(2'b00, 16'h2 << (NX16 - 2), 16'h0, NX16, 0, 0, 0);
    wait_rdy("R7 ready after clear", 1'b1);
    rd(16'd7, NX16, 16, 0, w0, w1, dm);
    chk("R7 clear all", w0, 16'hFFFF);
    chk("R7 clear all next", w1, 16'hFFFF);

    org16 = 1'b0;
    wr(2'b01, 16'd5, 16'h003C, NX8, 8, 0, 0);
    wait_rdy("R5 ready byte", 1'b1);
    rd(16'd5, NX8, 8, 0, w0, w1, dm);
    chk("R2 byte dummy", 16'(dm), 16'h0);
    chk("R5 byte readback", w0, 16'h003C);
    chk("R3 byte next", w1, 16'h00FF);

    special(2'b00, NX8);
    wr(2'b01, 16'd6, 16'h0077, NX8, 8, 0, 0);
    wait_rdy("R4 disabled again no cycle", 1'b0);
    rd(16'd6, NX8, 8, 0, w0, w1, dm);
    chk("R4 disable sub-code blocks write", w0, 16'h00FF);
    rd(16'd5, NX8, 8, 0, w0, w1, dm);
    chk("R4 read while disabled", w0, 16'h003C);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule